// File: doc/BRIEF.md
# Pi/4 DQPSK Differential Phase Encoder

This block turns a serial transmit bit stream into constellation impulses for pi/4 differential quadrature phase shift keying. Bits arrive one per strobe; each pair of accepted bits forms a dibit, and the dibit selects a phase increment that is an odd multiple of pi/4. The increment is added to the phase of the previous symbol, so the data lives in the phase steps rather than in absolute positions, and the running phase visits eight points on a circle. For every completed dibit the block issues a one-cycle symbol strobe together with signed in-phase and quadrature words taken from the new phase.

A burst-start pulse returns the phase to its reference and primes the block so that the first two symbols of a burst are sent as if the dibit were zero, whatever bits arrive in those slots; the source sends filler there. A frequency-test control freezes the modulation: symbols still strobe out, but with the in-phase word at zero and the quadrature word at positive full scale. The words feed a pulse-shaping filter downstream.

Top module: `dqpsk_phase_encoder`

## Requirements
- R1: A synchronous active-low reset sets the phase index to 0, empties the dibit pairing state, clears the priming count, drives sym_vld low and both impulse words to 0.
- R2: Only bits presented with bit_vld high are accepted; the first accepted bit of a pair is X (dibit bit 1) and the second is Y (dibit bit 0).
- R3: Each completed dibit {X,Y} advances a 3-bit phase index (units of pi/4, modulo 8) by 1 for 00, 3 for 01, 5 for 11 and 7 for 10; the first symbol after reset or burst start is applied to index 0.
- R4: Phase index k maps to angle k*pi/4 with I = FS*cos and Q = FS*sin, two's complement on W bits: axis points give +/-511 and diagonal points +/-361 at the defaults (W = 10, FS = 511).
- R5: sym_vld is high for exactly one cycle, starting at the clock edge that accepts Y; i_out and q_out change only at that edge and hold otherwise.
- R6: burst_start sets the phase index to 0, discards a half-received dibit, and forces the next two completed dibits to be treated as 00 whatever their bits.
- R7: When burst_start and bit_vld are high in the same cycle, burst_start wins: the bit is discarded and no symbol is produced at that edge.
- R8: While ftest is high each completed dibit still produces sym_vld, with i_out = 0 and q_out = +FS, and the phase index does not move; the priming count still decrements.
- R9: Changes on bit_in while bit_vld is low have no effect on outputs or on the pairing of later bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_vld | input | 1 | Strobe qualifying bit_in |
| bit_in | input | 1 | Serial data bit |
| burst_start | input | 1 | Burst-start pulse: phase reference and two-symbol priming |
| ftest | input | 1 | Frequency-test mode, freezes modulation |
| sym_vld | output | 1 | One-cycle symbol strobe |
| i_out | output | W | Signed in-phase impulse |
| q_out | output | W | Signed quadrature impulse |

## Verification
The burst restart and the completion of a dibit can land on the same edge. The bench provokes this by sending one bit, then presenting the next bit with burst_start raised in that very cycle; it judges the outcome by the absence of a symbol strobe after that edge and by the phases of the following symbols, which must show the discarded half-dibit, the two primed zero dibits starting from index 0, and correct pairing of the bits after them.

// File: rtl/dqpsk_pkg.sv
// Package: shared types and the dibit-to-step mapping of the phase encoder.
// Assumes the phase is counted in units of pi/4, eight states per turn.
package dqpsk_pkg;
    localparam int PH_W = 3;
    typedef logic [PH_W-1:0] phase_t;
    typedef logic [1:0]      dibit_t;

    // Phase step for a dibit {X,Y}: 00 -> +1, 01 -> +3, 11 -> -3, 10 -> -1 (mod 8).
    function automatic phase_t phase_step(input dibit_t db);
        case (db)
            2'b00:   return phase_t'(1);
            2'b01:   return phase_t'(3);
            2'b11:   return phase_t'(5);
            default: return phase_t'(7);
        endcase
    endfunction
endpackage

// File: rtl/dqpsk_dibit_pack.sv
// Module: collects accepted serial bits into dibits and applies burst priming.
// pair_vld and dibit are combinational and valid in the cycle Y is presented.
// Assumes burst_start is a pulse; it overrides any bit presented with it.
module dqpsk_dibit_pack
    import dqpsk_pkg::*;
#(
    parameter int PRIME_SYMS = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   bit_vld,
    input  logic   bit_in,
    input  logic   burst_start,
    output logic   pair_vld,
    output dibit_t dibit
);
    localparam int CW = $clog2(PRIME_SYMS + 1);

    logic          have_x;
    logic          x_q;
    logic [CW-1:0] prime_q;

    // Pair completes on the second accepted bit unless a burst restart wins.
    always_comb begin
        pair_vld = bit_vld && have_x && !burst_start;
        dibit    = (prime_q != '0) ? 2'b00 : {x_q, bit_in};
    end

    // Track the held first bit and the remaining primed symbols.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_x  <= 1'b0;
            x_q     <= 1'b0;
            prime_q <= '0;
        end else if (burst_start) begin
            have_x  <= 1'b0;
            prime_q <= CW'(PRIME_SYMS);
        end else if (bit_vld) begin
            if (have_x) begin
                have_x <= 1'b0;
                if (prime_q != '0) begin
                    prime_q <= prime_q - CW'(1);
                end
            end else begin
                have_x <= 1'b1;
                x_q    <= bit_in;
            end
        end
    end

    // A finished pair leaves the packer waiting for a fresh X (R2).
    p_pair_rearm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pair_vld |=> !have_x);

    // Each primed symbol consumes one count (R6).
    p_prime_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_vld && prime_q != '0) |=> (prime_q == $past(prime_q) - CW'(1)));

    // A burst restart always leaves a full priming count and no held bit (R6).
    p_burst_prime_r6: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |=> (prime_q == CW'(PRIME_SYMS) && !have_x));
endmodule

// File: rtl/dqpsk_phase_acc.sv
// Module: eight-state phase accumulator advanced by each completed dibit.
// phase_d is the value the register takes at the next edge.
// Assumes clear (burst start) and pair_vld never both qualify a step.
module dqpsk_phase_acc
    import dqpsk_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pair_vld,
    input  dibit_t dibit,
    input  logic   hold,
    input  logic   clear,
    output phase_t phase_d,
    output phase_t phase_q
);
    // Next phase: cleared on burst start, stepped by a dibit unless held.
    always_comb begin
        phase_d = phase_q;
        if (clear) begin
            phase_d = '0;
        end else if (pair_vld && !hold) begin
            phase_d = phase_q + phase_step(dibit);
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Every step is an odd multiple of pi/4 (R3).
    p_step_odd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_vld && !hold && !clear) |=> (phase_q[0] != $past(phase_q[0])));

    // Test mode freezes the phase (R8).
    p_hold_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_vld && hold) |=> (phase_q == $past(phase_q)));

    // Burst start returns to the reference (R6).
    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (phase_q == '0));
endmodule

// File: rtl/dqpsk_iq_map.sv
// Module: maps the new phase index to registered signed I/Q impulses.
// Assumes FS < 2**(W-1); the diagonal level is FS/sqrt(2) rounded.
module dqpsk_iq_map
    import dqpsk_pkg::*;
#(
    parameter int W  = 10,
    parameter int FS = 511
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pair_vld,
    input  logic                ftest,
    input  phase_t              phase_d,
    output logic                sym_vld,
    output logic signed [W-1:0] i_out,
    output logic signed [W-1:0] q_out
);
    localparam int NPTS = 1 << PH_W;
    localparam int DIAG = $rtoi($itor(FS) * 0.7071067811865476 + 0.5);

    logic signed [W-1:0] lut_i [NPTS];
    logic signed [W-1:0] lut_q [NPTS];

    for (genvar k = 0; k < NPTS; k++) begin : g_pt
        localparam int CI = (k == 0) ? FS :
                            (k == 1 || k == 7) ? DIAG :
                            (k == 2 || k == 6) ? 0 :
                            (k == 3 || k == 5) ? -DIAG : -FS;
        localparam int CQ = (k == 2) ? FS :
                            (k == 1 || k == 3) ? DIAG :
                            (k == 0 || k == 4) ? 0 :
                            (k == 5 || k == 7) ? -DIAG : -FS;
        assign lut_i[k] = W'(CI);
        assign lut_q[k] = W'(CQ);
    end

    // Output register: strobe per symbol, words follow the new phase or test value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_vld <= 1'b0;
            i_out   <= '0;
            q_out   <= '0;
        end else begin
            sym_vld <= pair_vld;
            if (pair_vld) begin
                if (ftest) begin
                    i_out <= '0;
                    q_out <= W'(FS);
                end else begin
                    i_out <= lut_i[phase_d];
                    q_out <= lut_q[phase_d];
                end
            end
        end
    end

    // Strobe never lasts two cycles (R5).
    p_sym_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld |=> !sym_vld);

    // Words hold between symbols (R5).
    p_iq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_vld |=> ($stable(i_out) && $stable(q_out)));

    // Test mode output values (R8).
    p_ftest_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_vld && ftest) |=> (i_out == '0 && q_out == W'(FS)));
endmodule

// File: rtl/dqpsk_phase_encoder.sv
// Module: top of the pi/4 DQPSK differential phase encoder.
// Bits -> dibits -> accumulated phase -> registered I/Q impulses, one
// strobe per dibit, with burst priming and a static test mode.
// Assumes burst_start and ftest are synchronous to clk.
module dqpsk_phase_encoder
    import dqpsk_pkg::*;
#(
    parameter int W          = 10,
    parameter int FS         = 511,
    parameter int PRIME_SYMS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_vld,
    input  logic                bit_in,
    input  logic                burst_start,
    input  logic                ftest,
    output logic                sym_vld,
    output logic signed [W-1:0] i_out,
    output logic signed [W-1:0] q_out
);
    logic   pair_vld;
    dibit_t dibit;
    phase_t phase_d;
    phase_t phase_q;

    dqpsk_dibit_pack #(.PRIME_SYMS(PRIME_SYMS)) u_pack (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_vld     (bit_vld),
        .bit_in      (bit_in),
        .burst_start (burst_start),
        .pair_vld    (pair_vld),
        .dibit       (dibit)
    );

    dqpsk_phase_acc u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .pair_vld (pair_vld),
        .dibit    (dibit),
        .hold     (ftest),
        .clear    (burst_start),
        .phase_d  (phase_d),
        .phase_q  (phase_q)
    );

    dqpsk_iq_map #(.W(W), .FS(FS)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .pair_vld (pair_vld),
        .ftest    (ftest),
        .phase_d  (phase_d),
        .sym_vld  (sym_vld),
        .i_out    (i_out),
        .q_out    (q_out)
    );

    // A burst restart never yields a symbol at its edge (R7).
    p_burst_no_sym_r7: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |=> !sym_vld);
endmodule

// File: tb/dqpsk_phase_encoder_tb.sv
`timescale 1ns/1ps
module dqpsk_phase_encoder_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_vld = 1'b0;
    logic bit_in = 1'b0;
    logic burst_start = 1'b0;
    logic ftest = 1'b0;
    logic sym_vld;
    logic signed [9:0] i_out;
    logic signed [9:0] q_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Entries {X, Y, expected phase index after the symbol}.
    localparam logic [4:0] VEC [12] = '{
        5'b00_001, 5'b01_100, 5'b11_001, 5'b10_000,
        5'b10_111, 5'b01_010, 5'b11_111, 5'b00_000,
        5'b01_011, 5'b01_110, 5'b11_011, 5'b10_010
    };

    always #10 clk = ~clk;

    dqpsk_phase_encoder u_dut (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .burst_start(burst_start), .ftest(ftest),
        .sym_vld(sym_vld), .i_out(i_out), .q_out(q_out)
    );

    function automatic int exp_i(input int k);
        case (k)
            0: return 511;  1: return 361;  2: return 0;    3: return -361;
            4: return -511; 5: return -361; 6: return 0;    default: return 361;
        endcase
    endfunction

    function automatic int exp_q(input int k);
        return exp_i((k + 6) % 8);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_vld = 1'b1;
        bit_in  = b;
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    // Sends X then Y and checks strobe timing and the words.
    task automatic send_sym(input logic x, input logic y, input int ei, input int eq,
                            input string tag);
        send_bit(x);
        chk(sym_vld == 1'b0, {tag, " no strobe after X"}, int'(sym_vld), 0);
        send_bit(y);
        chk(sym_vld == 1'b1, {tag, " strobe after Y"}, int'(sym_vld), 1);
        chk(int'(i_out) == ei, {tag, " I"}, int'(i_out), ei);
        chk(int'(q_out) == eq, {tag, " Q"}, int'(q_out), eq);
        @(negedge clk);
        chk(sym_vld == 1'b0, {tag, " R5 strobe one cycle"}, int'(sym_vld), 0);
    endtask

    task automatic burst_pulse();
        @(negedge clk);
        burst_start = 1'b1;
        @(negedge clk);
        burst_start = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(sym_vld == 1'b0, "R1 sym_vld in reset", int'(sym_vld), 0);
        chk(i_out == '0, "R1 I in reset", int'(i_out), 0);
        chk(q_out == '0, "R1 Q in reset", int'(q_out), 0);
        rst_n = 1'b1;

        // R2 R3 R4: table walk from index 0.
        foreach (VEC[n]) begin
            send_sym(VEC[n][4], VEC[n][3], exp_i(int'(VEC[n][2:0])),
                     exp_q(int'(VEC[n][2:0])), $sformatf("R3 R4 vec%0d", n));
        end

        // R6: burst restart, two primed zero dibits, then data. Phase was 2.
        burst_pulse();
        chk(sym_vld == 1'b0, "R6 no strobe on burst", int'(sym_vld), 0);
        send_sym(1'b1, 1'b1, exp_i(1), exp_q(1), "R6 primed 1");
        send_sym(1'b1, 1'b0, exp_i(2), exp_q(2), "R6 primed 2");
        send_sym(1'b0, 1'b1, exp_i(5), exp_q(5), "R6 first data");

        // R7: burst with the Y bit in the same cycle; half dibit discarded.
        send_bit(1'b1);
        @(negedge clk);
        bit_vld = 1'b1;
        bit_in = 1'b0;
        burst_start = 1'b1;
        @(negedge clk);
        bit_vld = 1'b0;
        burst_start = 1'b0;
        chk(sym_vld == 1'b0, "R7 collision no strobe", int'(sym_vld), 0);
        send_sym(1'b0, 1'b1, exp_i(1), exp_q(1), "R7 primed 1");
        send_sym(1'b0, 1'b0, exp_i(2), exp_q(2), "R7 primed 2");
        send_sym(1'b1, 1'b1, exp_i(7), exp_q(7), "R7 pairing after");

        // R8: test mode freezes phase at 7.
        ftest = 1'b1;
        send_sym(1'b0, 1'b1, 0, 511, "R8 ftest a");
        send_sym(1'b1, 1'b1, 0, 511, "R8 ftest b");
        ftest = 1'b0;
        send_sym(1'b0, 1'b0, exp_i(0), exp_q(0), "R8 phase held");

        // R9: bit_in toggles with bit_vld low are ignored.
        for (int t = 0; t < 6; t++) begin
            @(negedge clk);
            bit_in = t[0];
            chk(sym_vld == 1'b0, "R9 ignored bit", int'(sym_vld), 0);
        end
        chk(i_out == 10'sd511, "R9 I unchanged", int'(i_out), 511);
        send_sym(1'b1, 1'b0, exp_i(7), exp_q(7), "R9 pairing intact");

        // R1: mid-stream reset clears the half dibit and the phase.
        send_bit(1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(sym_vld == 1'b0, "R1 reset sym", int'(sym_vld), 0);
        chk(i_out == '0, "R1 reset I", int'(i_out), 0);
        chk(q_out == '0, "R1 reset Q", int'(q_out), 0);
        rst_n = 1'b1;
        send_sym(1'b0, 1'b0, exp_i(1), exp_q(1), "R1 after reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule